// File: doc/BRIEF.md
# Interval timer programming front end

This block sits between a CPU byte bus and a three-counter interval timer. The bus has four byte addresses. Addresses 0, 1 and 2 are the data ports of counters 0, 1 and 2, and address 3 is the control register.

A byte written to the control register is decoded into one of three things:
- a counter programming word, which stores a byte-access format, a mode number and a BCD flag for one counter;
- a latch request for one counter;
- a read-back command.

Once a counter is programmed, the block assembles the bytes written to its data port into 16-bit initial counts, following the stored format, and announces each complete count with a one-cycle load strobe. Reads of a data port return bytes of the counting engine's value, in the same stored order.

The counting engines, the per-mode output behaviour and the read-back status contents are outside this block. The latch request and the read-back command leave the block only as strobes. A counter may be given a new initial count at any time after it is programmed, with no need to rewrite its control word.

Top module: `timer_ctl_loader`

## Requirements
- R1: A control byte (address 3) with bits [7:6] = 11 is a read-back command. It pulses `readback_stb` for one cycle, starting the cycle after the write. It changes no stored mode or BCD flag and raises no latch strobe, whatever bits [5:4] hold.
- R2: A control byte with bits [7:6] = 00, 01 or 10 selects counter 0, 1 or 2. If bits [5:4] = 00, it is a latch request: `latch_stb[n]` pulses for one cycle after the write, and the counter's stored mode, BCD flag and format are unchanged.
- R3: A programming word stores a mode from bits [3:1] on `mode_o[3n+2:3n]`: 000→0, 001→1, x10→2, x11→3, 100→4, 101→5.
- R4: Bit 0 of a programming word is stored as that counter's BCD flag on `bcd_o[n]`.
- R5: Data bytes written to a counter that has never been programmed since reset produce no load strobe.
- R6: Bits [5:4] of a programming word set the format. With format 01 (low byte only), each data write loads {8'h00, byte}. With format 10 (high byte only), each data write loads {byte, 8'h00}. `load_stb[n]` and `load_val` appear the cycle after the write.
- R7: With format 11, the first data byte is held as the low byte. No strobe fires until the second byte arrives; that byte then loads {second, first}.
- R8: Further data writes after a load reload the counter with the stored format, without a new control word.
- R9: A programming word for a counter discards any held partial low byte. It also restarts both that counter's write sequence and its read sequence at the low byte.
- R10: Reading a data port returns a byte of `cnt_value` for that counter, combinationally on `rdata`. Format 01 returns the low byte, format 10 the high byte, and format 11 alternates low then high on successive reads. An unprogrammed counter reads 0x00.
- R11: After synchronous reset, all counters are unprogrammed, and all modes, BCD flags and strobes are 0.
- R12: A read and a data write to the same counter in the same cycle each advance their own sequence independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 2 | Address: 0 to 2 counter data, 3 control |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte (combinational) |
| cnt_value | input | 48 | Current value of counters 2, 1, 0, 16 bits each |
| load_stb | output | 3 | One-hot initial-count load strobe per counter |
| load_val | output | 16 | Initial count that accompanies `load_stb` |
| latch_stb | output | 3 | Latch request strobe per counter |
| readback_stb | output | 1 | Read-back command strobe |
| mode_o | output | 9 | Stored mode number per counter, 3 bits each |
| bcd_o | output | 3 | Stored BCD flag per counter |

## Verification
The two functions that can share a cycle are the write-byte sequence and the read-byte sequence of one counter. A CPU read and a data write to the same port can arrive together.

The bench provokes this collision on a two-byte counter: it asserts the read and the write of the low byte in the same cycle. It then judges the outcome by three results:
- the read returns the low byte;
- the following read returns the high byte;
- the next write completes a load whose value is built from both written bytes.

Each sequence must therefore advance on its own.

// File: rtl/tcl_pkg.sv
package tcl_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int NUM_CH = 3;
    localparam int ADDR_W = 2;
    localparam int MODE_W = 3;
    localparam logic [ADDR_W-1:0] CTL_ADDR = 2'd3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_BOTH  = 2'b11
    } acc_e;

    typedef struct packed {
        logic              rb;
        logic [1:0]        sel;
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } ctl_s;

    // x10 and x11 fold to modes 2 and 3; the other codes map straight through
    function automatic logic [MODE_W-1:0] mode_num(input logic [MODE_W-1:0] m);
        if (m[1]) return {1'b0, m[1:0]};
        return m;
    endfunction
endpackage

// File: rtl/tcl_decode.sv
module tcl_decode
    import tcl_pkg::*;
(
    input  logic [BYTE_W-1:0] ctl_byte,
    output ctl_s              ctl
);
    always_comb begin
        ctl.sel  = ctl_byte[7:6];
        ctl.rb   = (ctl_byte[7:6] == 2'b11);
        ctl.acc  = acc_e'(ctl_byte[5:4]);
        ctl.mode = mode_num(ctl_byte[3:1]);
        ctl.bcd  = ctl_byte[0];
    end
endmodule

// File: rtl/tcl_channel.sv
module tcl_channel
    import tcl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              latch_cmd,
    input  ctl_s              ctl,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd_adv,
    input  logic [CNT_W-1:0]  value_i,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output logic [MODE_W-1:0] mode_o,
    output logic              bcd_o
);
    logic              prog_q;
    acc_e              fmt_q;
    logic [MODE_W-1:0] mode_q;
    logic              bcd_q;
    logic              wr_hi_q;
    logic              rd_hi_q;
    logic [BYTE_W-1:0] lo_hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q    <= 1'b0;
            fmt_q     <= ACC_LATCH;
            mode_q    <= '0;
            bcd_q     <= 1'b0;
            wr_hi_q   <= 1'b0;
            rd_hi_q   <= 1'b0;
            lo_hold_q <= '0;
            load_stb  <= 1'b0;
            load_val  <= '0;
        end else begin
            load_stb <= 1'b0;
            if (ctl_wr) begin
                prog_q    <= 1'b1;
                fmt_q     <= ctl.acc;
                mode_q    <= ctl.mode;
                bcd_q     <= ctl.bcd;
                wr_hi_q   <= 1'b0;
                rd_hi_q   <= 1'b0;
                lo_hold_q <= '0;
            end else begin
                if (data_wr && prog_q) begin
                    unique case (fmt_q)
                        ACC_LO: begin
                            load_stb <= 1'b1;
                            load_val <= {{BYTE_W{1'b0}}, wdata};
                        end
                        ACC_HI: begin
                            load_stb <= 1'b1;
                            load_val <= {wdata, {BYTE_W{1'b0}}};
                        end
                        ACC_BOTH: begin
                            if (!wr_hi_q) begin
                                lo_hold_q <= wdata;
                                wr_hi_q   <= 1'b1;
                            end else begin
                                load_stb <= 1'b1;
                                load_val <= {wdata, lo_hold_q};
                                wr_hi_q  <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
                if (rd_adv && prog_q && fmt_q == ACC_BOTH)
                    rd_hi_q <= ~rd_hi_q;
            end
        end
    end

    always_comb begin
        rd_byte = '0;
        if (prog_q) begin
            unique case (fmt_q)
                ACC_LO:   rd_byte = value_i[BYTE_W-1:0];
                ACC_HI:   rd_byte = value_i[CNT_W-1:BYTE_W];
                ACC_BOTH: rd_byte = rd_hi_q ? value_i[CNT_W-1:BYTE_W]
                                            : value_i[BYTE_W-1:0];
                default:  rd_byte = '0;
            endcase
        end
    end

    assign mode_o = mode_q;
    assign bcd_o  = bcd_q;

    p_unprog_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (!prog_q && data_wr && !ctl_wr) |=> !load_stb);

    p_latch_keeps_cfg_r2: assert property (@(posedge clk) disable iff (rst)
        latch_cmd |=> ($stable(mode_q) && $stable(bcd_q) && $stable(fmt_q)));

    p_ctl_restarts_seq_r9: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (!wr_hi_q && !rd_hi_q && !load_stb));

    p_pair_needs_high_r7: assert property (@(posedge clk) disable iff (rst)
        (load_stb && fmt_q == ACC_BOTH) |-> $past(wr_hi_q));
endmodule

// File: rtl/timer_ctl_loader.sv
module timer_ctl_loader
    import tcl_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [1:0]               addr,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata,
    input  logic [NUM_CH*CNT_W-1:0]  cnt_value,
    output logic [NUM_CH-1:0]        load_stb,
    output logic [CNT_W-1:0]         load_val,
    output logic [NUM_CH-1:0]        latch_stb,
    output logic                     readback_stb,
    output logic [NUM_CH*MODE_W-1:0] mode_o,
    output logic [NUM_CH-1:0]        bcd_o
);
    ctl_s              ctl;
    logic              ctl_hit;
    logic [NUM_CH-1:0] ctl_wr, latch_cmd;
    logic [CNT_W-1:0]  ch_load_val [NUM_CH];
    logic [BYTE_W-1:0] ch_rd_byte  [NUM_CH];

    assign ctl_hit = wr_en && (addr == CTL_ADDR);

    tcl_decode u_dec (.ctl_byte(wdata), .ctl(ctl));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel_me;
        assign sel_me       = ctl_hit && !ctl.rb && (ctl.sel == 2'(i));
        assign ctl_wr[i]    = sel_me && (ctl.acc != ACC_LATCH);
        assign latch_cmd[i] = sel_me && (ctl.acc == ACC_LATCH);

        tcl_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .ctl_wr   (ctl_wr[i]),
            .latch_cmd(latch_cmd[i]),
            .ctl      (ctl),
            .data_wr  (wr_en && addr == ADDR_W'(i)),
            .wdata    (wdata),
            .rd_adv   (rd_en && addr == ADDR_W'(i)),
            .value_i  (cnt_value[i*CNT_W +: CNT_W]),
            .rd_byte  (ch_rd_byte[i]),
            .load_stb (load_stb[i]),
            .load_val (ch_load_val[i]),
            .mode_o   (mode_o[i*MODE_W +: MODE_W]),
            .bcd_o    (bcd_o[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_stb    <= '0;
            readback_stb <= 1'b0;
        end else begin
            latch_stb    <= latch_cmd;
            readback_stb <= ctl_hit && ctl.rb;
        end
    end

    always_comb begin
        load_val = '0;
        rdata    = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (load_stb[i]) load_val = ch_load_val[i];
            if (addr == ADDR_W'(i)) rdata = ch_rd_byte[i];
        end
    end

    p_load_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_stb));

    p_readback_only_r1: assert property (@(posedge clk) disable iff (rst)
        (ctl_hit && wdata[7:6] == 2'b11) |=> (readback_stb && latch_stb == '0));

    p_latch_single_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(latch_stb) <= 1);
endmodule

// File: tb/timer_ctl_loader_test.sv
`timescale 1ns/1ps
module timer_ctl_loader_test;
    logic        clk = 0, rst = 1;
    logic        wr_en = 0, rd_en = 0;
    logic [1:0]  addr = 0;
    logic [7:0]  wdata = 0;
    logic [7:0]  rdata;
    logic [47:0] cnt_value = 48'hC0DE_BEEF_1357;
    logic [2:0]  load_stb, latch_stb, bcd_o;
    logic [15:0] load_val;
    logic        readback_stb;
    logic [8:0]  mode_o;

    int total = 0, fails = 0;
    bit done = 0;
    logic [17:0] exp_q[$];

    always #2.5 clk = ~clk;

    timer_ctl_loader uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic expect_load(input int ch, input logic [15:0] v);
        exp_q.push_back({2'(ch), v});
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string req);
        @(negedge clk); rd_en = 1; addr = a; #1;
        chk(rdata == e, req, rdata, e);
        @(negedge clk); rd_en = 0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && |load_stb) begin
            if (exp_q.size() == 0) begin
                chk(0, "R5 unexpected load", load_stb, 0);
            end else begin
                logic [17:0] e;
                e = exp_q.pop_front();
                chk(load_stb == (3'b1 << e[17:16]), "R6/R7/R8 load strobe", load_stb, 3'b1 << e[17:16]);
                chk(load_val == e[15:0], "R6/R7/R8 load value", load_val, e[15:0]);
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk(mode_o == 0 && bcd_o == 0, "R11 mode/bcd reset", {mode_o, bcd_o}, 0);
        chk(load_stb == 0 && latch_stb == 0 && !readback_stb, "R11 strobes reset", load_stb, 0);
        rd(2'd0, 8'h00, "R10/R11 unprogrammed read");

        wr(2'd1, 8'h55);
        chk(load_stb == 0, "R5 unprogrammed write", load_stb, 0);

        wr(2'd3, 8'h1D);   // ch0 low-only, mode 110, bcd 1
        chk(mode_o[2:0] == 2, "R3 mode x10", mode_o[2:0], 2);
        chk(bcd_o[0] == 1, "R4 bcd set", bcd_o[0], 1);
        wr(2'd3, 8'h6A);   // ch1 high-only, mode 101
        chk(mode_o[5:3] == 5, "R3 mode 101", mode_o[5:3], 5);
        chk(bcd_o[1] == 0, "R4 bcd clear", bcd_o[1], 0);
        wr(2'd3, 8'hBE);   // ch2 two-byte, mode 111
        chk(mode_o[8:6] == 3, "R3 mode x11", mode_o[8:6], 3);

        expect_load(0, 16'h0042); wr(2'd0, 8'h42);
        expect_load(1, 16'h3700); wr(2'd1, 8'h37);
        wr(2'd2, 8'h34);
        chk(load_stb == 0, "R7 no strobe after low", load_stb, 0);
        expect_load(2, 16'h1234); wr(2'd2, 8'h12);
        expect_load(2, 16'hBBAA); wr(2'd2, 8'hAA); wr(2'd2, 8'hBB);
        expect_load(0, 16'h0099); wr(2'd0, 8'h99);

        wr(2'd2, 8'h11);   // partial, then reprogram
        wr(2'd3, 8'hB0);
        chk(mode_o[8:6] == 0, "R9/R3 mode 000", mode_o[8:6], 0);
        expect_load(2, 16'h2233); wr(2'd2, 8'h33); wr(2'd2, 8'h22);

        wr(2'd3, 8'h47);   // latch ch1
        chk(latch_stb == 3'b010, "R2 latch strobe", latch_stb, 3'b010);
        chk(mode_o[5:3] == 5 && bcd_o[1] == 0, "R2 mode kept", mode_o[5:3], 5);
        expect_load(1, 16'h5500); wr(2'd1, 8'h55);

        wr(2'd3, 8'hFF);   // read-back
        chk(readback_stb == 1, "R1 readback strobe", readback_stb, 1);
        chk(latch_stb == 0, "R1 no latch", latch_stb, 0);
        chk(mode_o == {3'd0, 3'd5, 3'd2} && bcd_o == 3'b001, "R1 config kept", mode_o, {3'd0, 3'd5, 3'd2});

        rd(2'd0, 8'h57, "R10 low-only"); rd(2'd0, 8'h57, "R10 low-only again");
        rd(2'd1, 8'hBE, "R10 high-only");
        rd(2'd2, 8'hDE, "R10 pair low"); rd(2'd2, 8'hC0, "R10 pair high");
        rd(2'd2, 8'hDE, "R10 pair wrap");
        wr(2'd3, 8'hB0);
        rd(2'd2, 8'hDE, "R9 read restart");

        // R12: simultaneous read and write on ch2
        wr(2'd3, 8'hB0);
        @(negedge clk); wr_en = 1; rd_en = 1; addr = 2'd2; wdata = 8'h66; #1;
        chk(rdata == 8'hDE, "R12 read in write cycle", rdata, 8'hDE);
        @(negedge clk); wr_en = 0; rd_en = 0;
        rd(2'd2, 8'hC0, "R12 read advanced");
        expect_load(2, 16'h7766); wr(2'd2, 8'h77);

        wr(2'd3, 8'h14); chk(mode_o[2:0] == 2, "R3 mode 010", mode_o[2:0], 2);
        wr(2'd3, 8'h18); chk(mode_o[2:0] == 4, "R3 mode 100", mode_o[2:0], 4);
        wr(2'd3, 8'h12); chk(mode_o[2:0] == 1, "R3 mode 001", mode_o[2:0], 1);
        wr(2'd3, 8'h16); chk(mode_o[2:0] == 3, "R3 mode 011", mode_o[2:0], 3);
        wr(2'd3, 8'h10); chk(mode_o[2:0] == 0, "R3 mode 000", mode_o[2:0], 0);

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R6/R7/R8 missing loads", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule